// File: doc/BRIEF.md
# Synchronous Boost Gate Sequencer

This block drives the two switches of a synchronous boost power stage: the low-side main switch that charges the inductor and the high-side rectifier that passes inductor current to the output. It works one switching period at a time. A tick from the switching oscillator opens each period. The analog loop is represented by digital flags: a comparator trip when the sensed current ramp meets the control level, a peak-current-limit flag and an inductor zero-crossing flag. The sequencer turns these into non-overlapping gate commands.

Every period forces a low-side pulse of at least a minimum length, so no period is skipped even at no load. The on time is also capped at a maximum, and break-before-make dead time is inserted on both transitions. The rectifier is turned off as soon as the inductor current reaches zero, which prevents reverse current at light load. All time limits are counted in system-clock cycles and set by parameters. Dropping the enable turns both gates off at once and parks the block until a later tick.

Top module: `boost_gate_seq`

## Requirements
- R1: After reset, and one clock after enable goes low, both gate outputs are low and the phase output reads 0 (idle).
- R2: In idle with enable high, a tick turns the low-side gate on at the next clock with the high-side gate off. Ticks that arrive while the low-side gate is on or during dead time have no effect on the period.
- R3: After at least MIN_ON_CYC on cycles, a comparator trip sampled in on cycle k ends the low-side pulse after exactly k cycles.
- R4: The low-side pulse lasts at least MIN_ON_CYC cycles even when the trip is asserted from its first cycle.
- R5: With no trip and no limit flag, the low-side pulse ends after exactly MAX_ON_CYC cycles.
- R6: The current-limit flag ends the low-side pulse in the same way as the trip, independent of the trip input.
- R7: Between the end of the low-side pulse and the start of the high-side pulse, both gates are low for exactly DEAD_CYC cycles.
- R8: The high-side gate stays on until a tick. After the tick, both gates are low for exactly DEAD_CYC cycles and then the low-side gate turns on.
- R9: A zero-crossing flag while the high-side gate is on turns it off at the next clock. Both gates then stay low, with phase 5, until a tick, which is followed by DEAD_CYC off cycles and a new low-side pulse.
- R10: When enable goes low, both gates fall in the same cycle, without waiting for a clock. After enable returns, nothing switches until a tick.
- R11: The two gates are never high in the same cycle.
- R12: The phase output encodes 0 idle, 1 low-side on, 2 dead time before the rectifier, 3 high-side on, 4 dead time before the main switch, 5 rectifier released after zero crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enable; low forces both gates off |
| tick_i | input | 1 | One-clock pulse opening a switching period |
| trip_i | input | 1 | PWM comparator trip flag |
| ilim_i | input | 1 | Peak current limit flag |
| zc_i | input | 1 | Inductor zero-crossing flag |
| ls_gate_o | output | 1 | Low-side (main) switch gate |
| hs_gate_o | output | 1 | High-side (rectifier) switch gate |
| phase_o | output | 3 | Current phase of the period (encoding in R12) |

## Verification
The bench builds the block with DEAD_CYC=2, MIN_ON_CYC=3 and MAX_ON_CYC=10. With these values a whole period fits in a few dozen clocks. The minimum and maximum clamps can be told apart from a trip in the middle of the window: a trip at cycle 5 gives 5, an early trip gives 3, and no trip gives 10. A two-cycle dead time also separates an off-by-one error in the dead-time counter from correct behaviour.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LS_ON   = 3'd1,
    PH_DT_LH   = 3'd2,
    PH_HS_ON   = 3'd3,
    PH_DT_HL   = 3'd4,
    PH_HS_HOLD = 3'd5
  } phase_e;

  // Low-side pulse may end in the cycle whose count is cnt.
  function automatic logic ls_may_end(input int unsigned cnt,
                                      input int unsigned min_on,
                                      input int unsigned max_on,
                                      input logic        stop_req);
    return (cnt >= max_on) || (stop_req && (cnt >= min_on));
  endfunction

  // Dead interval is complete in the cycle whose count is cnt.
  function automatic logic dead_elapsed(input int unsigned cnt,
                                        input int unsigned dead);
    return cnt >= dead;
  endfunction

endpackage

// File: rtl/bgs_run_counter.sv
module bgs_run_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_o <= '0;
    else if (load_i)
      cnt_o <= ONE;
    else if (run_i && (cnt_o != FULL))
      cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/bgs_ontime_eval.sv
module bgs_ontime_eval #(
  parameter int W          = 8,
  parameter int MIN_ON_CYC = 9,
  parameter int MAX_ON_CYC = 87
) (
  input  logic [W-1:0] cnt_i,
  input  logic         trip_i,
  input  logic         ilim_i,
  output logic         end_o
);
  import bgs_pkg::*;
  logic stop_req_w;

  assign stop_req_w = trip_i | ilim_i;
  assign end_o = ls_may_end(int'(cnt_i), MIN_ON_CYC, MAX_ON_CYC, stop_req_w);
endmodule

// File: rtl/bgs_dead_eval.sv
module bgs_dead_eval #(
  parameter int W        = 2,
  parameter int DEAD_CYC = 2
) (
  input  logic [W-1:0] cnt_i,
  output logic         done_o
);
  import bgs_pkg::*;
  assign done_o = dead_elapsed(int'(cnt_i), DEAD_CYC);
endmodule

// File: rtl/boost_gate_seq.sv
module boost_gate_seq #(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 9,
  parameter int MAX_ON_CYC = 87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       trip_i,
  input  logic       ilim_i,
  input  logic       zc_i,
  output logic       ls_gate_o,
  output logic       hs_gate_o,
  output logic [2:0] phase_o
);
  import bgs_pkg::*;

  localparam int ON_W = $clog2(MAX_ON_CYC + 1);
  localparam int DT_W = $clog2(DEAD_CYC + 1);

  phase_e state_q, state_d;

  logic [ON_W-1:0] on_cnt_w;
  logic [DT_W-1:0] dt_cnt_w;
  logic            ls_end_w;
  logic            dt_done_w;
  logic            on_load_w, on_run_w;
  logic            dt_load_w, dt_run_w;
  logic            in_dead_d_w;

  // Named events used by the phase logic
  assign in_dead_d_w = (state_d == PH_DT_LH) || (state_d == PH_DT_HL);
  assign on_load_w   = (state_d == PH_LS_ON) && (state_q != PH_LS_ON);
  assign on_run_w    = (state_d == PH_LS_ON) && (state_q == PH_LS_ON);
  assign dt_load_w   = in_dead_d_w && (state_d != state_q);
  assign dt_run_w    = in_dead_d_w && (state_d == state_q);

  bgs_run_counter #(.W(ON_W)) u_on_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (on_load_w),
    .run_i  (on_run_w),
    .cnt_o  (on_cnt_w)
  );

  bgs_run_counter #(.W(DT_W)) u_dt_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (dt_load_w),
    .run_i  (dt_run_w),
    .cnt_o  (dt_cnt_w)
  );

  bgs_ontime_eval #(
    .W          (ON_W),
    .MIN_ON_CYC (MIN_ON_CYC),
    .MAX_ON_CYC (MAX_ON_CYC)
  ) u_on_eval (
    .cnt_i  (on_cnt_w),
    .trip_i (trip_i),
    .ilim_i (ilim_i),
    .end_o  (ls_end_w)
  );

  bgs_dead_eval #(
    .W        (DT_W),
    .DEAD_CYC (DEAD_CYC)
  ) u_dt_eval (
    .cnt_i  (dt_cnt_w),
    .done_o (dt_done_w)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE:    if (tick_i)    state_d = PH_LS_ON;
        PH_LS_ON:   if (ls_end_w)  state_d = PH_DT_LH;
        PH_DT_LH:   if (dt_done_w) state_d = PH_HS_ON;
        PH_HS_ON: begin
          if (tick_i)    state_d = PH_DT_HL;
          else if (zc_i) state_d = PH_HS_HOLD;
        end
        PH_HS_HOLD: if (tick_i)    state_d = PH_DT_HL;
        PH_DT_HL:   if (dt_done_w) state_d = PH_LS_ON;
        default:                   state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  // Enable gates the outputs directly so they fall without a clock
  assign ls_gate_o = en_i && (state_q == PH_LS_ON);
  assign hs_gate_o = en_i && (state_q == PH_HS_ON);
  assign phase_o   = state_q;

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 9,
  parameter int MAX_ON_CYC = 87
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       ls_gate_o,
  input logic       hs_gate_o,
  input logic [2:0] phase_o
);
  logic [15:0] ls_run_q;
  logic [15:0] off_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_run_q  <= '0;
      off_run_q <= '0;
    end else begin
      ls_run_q  <= ls_gate_o ? ((ls_run_q == 16'hFFFF) ? ls_run_q : ls_run_q + 16'd1) : 16'd0;
      off_run_q <= (!ls_gate_o && !hs_gate_o)
                   ? ((off_run_q == 16'hFFFF) ? off_run_q : off_run_q + 16'd1) : 16'd0;
    end
  end

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_gate_o && hs_gate_o));

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!ls_gate_o && !hs_gate_o));

  // R1
  idle_after_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (phase_o == 3'd0));

  // R4
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ls_gate_o) && en_i) |-> (ls_run_q >= 16'(MIN_ON_CYC)));

  // R5
  max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate_o |-> (ls_run_q < 16'(MAX_ON_CYC)));

  // R7
  dead_lh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (off_run_q >= 16'(DEAD_CYC)));

  // R8
  dead_hl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_gate_o) && ($past(phase_o) == 3'd4)) |-> (off_run_q >= 16'(DEAD_CYC)));

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5) |-> (!ls_gate_o && !hs_gate_o));

endmodule

bind boost_gate_seq bgs_checker #(
  .DEAD_CYC   (DEAD_CYC),
  .MIN_ON_CYC (MIN_ON_CYC),
  .MAX_ON_CYC (MAX_ON_CYC)
) u_bgs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .ls_gate_o (ls_gate_o),
  .hs_gate_o (hs_gate_o),
  .phase_o   (phase_o)
);

// File: tb/boost_gate_seq_bench.sv
module boost_gate_seq_bench;
  localparam int DEAD = 2;
  localparam int MINO = 3;
  localparam int MAXO = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, trip = 1'b0, ilim = 1'b0, zc = 1'b0;
  logic ls, hs;
  logic [2:0] phase;

  int n_chk = 0;
  int n_err = 0;
  bit overlap_seen = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  boost_gate_seq #(.DEAD_CYC(DEAD), .MIN_ON_CYC(MINO), .MAX_ON_CYC(MAXO)) u_boost_gate_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick), .trip_i(trip),
    .ilim_i(ilim), .zc_i(zc), .ls_gate_o(ls), .hs_gate_o(hs), .phase_o(phase)
  );

  always @(negedge clk) if (rst_n && ls && hs) overlap_seen = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Low-side width; starts at a negedge with ls high, ends at first low sample
  task automatic count_ls(input int trip_at, input int ilim_at, input int tick_at,
                          output int w);
    w = 0;
    while (ls && w < 64) begin
      w++;
      if (w == trip_at) trip = 1'b1;
      if (w == ilim_at) ilim = 1'b1;
      tick = (w == tick_at);
      @(negedge clk);
    end
    trip = 1'b0; ilim = 1'b0; tick = 1'b0;
  endtask

  task automatic count_off(output int w);
    w = 0;
    while (!ls && !hs && w < 64) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic count_hs(input int zc_at, input int tick_at, output int w);
    w = 0;
    while (hs && w < 64) begin
      w++;
      zc   = (w == zc_at);
      tick = (w == tick_at);
      @(negedge clk);
    end
    zc = 1'b0; tick = 1'b0;
  endtask

  // Rest of a period after the low-side pulse: dead, rectifier, dead
  task automatic finish_period(input string req, input int hs_len);
    int w;
    count_off(w);
    check(w == DEAD, "R7", {req, " dead before rectifier"}, w, DEAD);
    check(hs && phase == 3'd3, "R12", "phase while rectifier on", phase, 3);
    count_hs(0, hs_len, w);
    check(w == hs_len, "R8", "rectifier held until tick", w, hs_len);
    count_off(w);
    check(w == DEAD, "R8", "dead before main switch", w, DEAD);
    check(ls == 1'b1, "R8", "main switch on after dead", ls, 1);
  endtask

  task automatic t_reset_idle();
    repeat (3) @(negedge clk);
    check(!ls && !hs && phase == 3'd0, "R1", "reset state", {ls, hs, phase}, 0);
    rst_n = 1'b1; en = 1'b1;
    repeat (4) @(negedge clk);
    check(!ls && !hs && phase == 3'd0, "R2", "idle without tick", {ls, hs, phase}, 0);
    send_tick();
    check(ls && !hs, "R2", "main switch on after tick", {ls, hs}, 2);
    check(phase == 3'd1, "R12", "phase main on", phase, 1);
  endtask

  task automatic t_trip_mid();
    int w;
    count_ls(5, 0, 0, w);
    check(w == 5, "R3", "trip ends pulse", w, 5);
    check(phase == 3'd2, "R12", "phase dead before rectifier", phase, 2);
    finish_period("R3", 6);
  endtask

  task automatic t_min_on();
    int w;
    count_ls(1, 0, 0, w);
    check(w == MINO, "R4", "minimum pulse", w, MINO);
    finish_period("R4", 4);
  endtask

  task automatic t_max_on();
    int w;
    count_ls(0, 0, 0, w);
    check(w == MAXO, "R5", "maximum pulse", w, MAXO);
    finish_period("R5", 3);
  endtask

  task automatic t_ilim();
    int w;
    count_ls(0, 4, 0, w);
    check(w == 4, "R6", "current limit ends pulse", w, 4);
    finish_period("R6", 5);
  endtask

  task automatic t_tick_ignored();
    int w;
    count_ls(6, 0, 2, w);
    check(w == 6, "R2", "tick during pulse ignored", w, 6);
    finish_period("R2", 4);
  endtask

  task automatic t_zero_cross();
    int w;
    bit held;
    count_ls(4, 0, 0, w);
    count_off(w);
    check(w == DEAD, "R7", "dead before rectifier", w, DEAD);
    count_hs(3, 0, w);
    check(w == 3, "R9", "zero crossing ends rectifier", w, 3);
    held = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (ls || hs || phase != 3'd5) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R9", "both off, phase 5, until tick", phase, 5);
    send_tick();
    count_off(w);
    check(w == DEAD - 1 + 1, "R9", "dead after tick", w, DEAD);
    check(ls == 1'b1, "R9", "main switch after hold", ls, 1);
  endtask

  task automatic t_enable_drop();
    bit quiet;
    en = 1'b0;
    #1;
    check(!ls && !hs, "R10", "gates fall with enable", {ls, hs}, 0);
    @(negedge clk);
    check(phase == 3'd0 && !ls && !hs, "R1", "idle after disable", phase, 0);
    en = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ls || hs || phase != 3'd0) quiet = 1'b0;
    end
    check(quiet, "R10", "no switching before tick", phase, 0);
    send_tick();
    check(ls && !hs, "R10", "restart on tick", {ls, hs}, 2);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_idle();
    t_trip_mid();
    t_min_on();
    t_max_on();
    t_ilim();
    t_tick_ignored();
    t_zero_cross();
    t_enable_drop();
    repeat (2) @(negedge clk);
    check(!overlap_seen, "R11", "gates never both high", overlap_seen, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule